// File: doc/BRIEF.md
# Dispatch Group Former

This block takes decoded instructions in program order, one per cycle, and packs the internal operations they expand into into fixed five-slot dispatch groups. Slots 0 to 3 hold non-branch operations and slot 4 holds only a branch. A group is closed when one of three things happens: a branch is placed, the non-branch slots are full, or the next instruction cannot fit. The closed group then goes to the back end in a single transfer. Each transfer carries a per-slot valid mask, the per-slot payload and a group tag. Later stages track whole groups instead of single operations.

Each instruction states how many operations it expands into. A plain instruction makes one operation. A cracked instruction makes two, and both must land in the same group. A millicoded instruction makes three or more. It starts in an empty group, emits its operations one per cycle, and may fill several groups in a row. A rolling tag and a count of outstanding groups stop more than `NGRP` groups from being in flight. A completion pulse returns the oldest tag. A flush drops whatever group is being built and any millicode remainder.

Top module: `group_former`

## Requirements
- R1: Slot 4 only ever carries a branch, and slots 0 to 3 never do. Accepting a branch (`in_br`=1, operation count ignored) places it in slot 4 with sub-index 0 and closes the group. Valid non-branch slots always form a contiguous run starting at slot 0.
- R2: Each slot word is `{instruction id, sub-index}`, with the id in the upper `IDW` bits and the sub-index in the lower `OPW` bits. Invalid slots read as zero. Operations appear in program order, and one instruction's operations occupy consecutive slots with sub-indices 0, 1, 2, and so on.
- R3: An operation count of 1, or of 0 (treated as 1), fills the next free non-branch slot. Filling the fourth non-branch slot closes the group.
- R4: A cracked instruction (count 2) places both operations in the same group. If only slot 3 is free, the group closes with slot 3 invalid, and the instruction stays unaccepted until the next group.
- R5: A millicoded instruction (count 3 or more) is accepted only into an empty group. Otherwise the current group closes first. Its first operation goes to slot 0 in the accept cycle, and the rest follow one per cycle. A group closes when four of them fill it or when the last one is placed.
- R6: `in_ready` is low while a closed group waits, while millicode operations remain, and during `flush`.
- R7: `grp_valid` is high exactly when a closed group exists, fewer than `NGRP` groups are outstanding, and `flush` is low. A transfer happens on `grp_valid && be_ready`. Until the transfer, the group's slots and tag hold stable.
- R8: Tags are assigned 0, 1, …, `NGRP`-1, 0, … in transfer order.
- R9: Each transfer raises the outstanding count and each `cmp_valid` pulse lowers it. With `NGRP` outstanding, no group is offered.
- R10: `flush` discards the building or closed group and any millicode remainder. The next cycle starts an empty group, and the tag and outstanding count are unchanged.
- R11: After reset, no group is offered, the first tag is 0, nothing is outstanding, and the group is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard the group under construction |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Instruction accepted this cycle when valid |
| in_id | input | IDW | Instruction identifier carried into slots |
| in_ops | input | OPW | Number of internal operations |
| in_br | input | 1 | Instruction is a branch |
| be_ready | input | 1 | Back end can take a group |
| cmp_valid | input | 1 | Oldest outstanding group completed |
| grp_valid | output | 1 | Group offered to the back end |
| grp_slot_vld | output | 5 | Per-slot valid, bit 4 is the branch slot |
| grp_slots | output | 5*(IDW+OPW) | Slot words, slot i at bits i*(IDW+OPW) upward |
| grp_tag | output | TW | Tag of the offered group |

## Verification
The assertions assume that `cmp_valid` is never pulsed while no group is outstanding. They also assume that completions return groups in the order the groups were sent, so a rolling tag suffices. The bench only raises `cmp_valid` when its own model counts at least one outstanding group. Directed sequences cover these cases:
- a cracked instruction arriving with one slot left
- a millicoded instruction of seven operations arriving after a partial group
- back-end stalls
- exhausting all tags
- flushes both mid-group and mid-millicode

A long random phase then mixes every instruction kind with random back-pressure, completions and flushes.

// File: rtl/group_former.sv
module group_former #(
  parameter int NGRP = 20,
  parameter int IDW  = 8,
  parameter int OPW  = 4,
  localparam int TW  = $clog2(NGRP),
  localparam int CW  = $clog2(NGRP + 1),
  localparam int SW  = IDW + OPW,
  localparam int NSL = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [IDW-1:0]     in_id,
  input  logic [OPW-1:0]     in_ops,
  input  logic               in_br,
  input  logic               be_ready,
  input  logic               cmp_valid,
  output logic               grp_valid,
  output logic [NSL-1:0]     grp_slot_vld,
  output logic [NSL*SW-1:0]  grp_slots,
  output logic [TW-1:0]      grp_tag
);

  logic           closed;
  logic [2:0]     cnt;
  logic [NSL-1:0] sv;
  logic [SW-1:0]  sd [NSL];
  logic           mc_on;
  logic [OPW-1:0] mc_left, mc_idx;
  logic [IDW-1:0] mc_id;
  logic [TW-1:0]  tag;
  logic [CW-1:0]  outst;

  logic [OPW-1:0] ops_e;
  logic           is_one, is_crk, fits, take, fire;

  assign ops_e    = (in_ops == '0) ? OPW'(1) : in_ops;
  assign is_one   = !in_br && ops_e == OPW'(1);
  assign is_crk   = !in_br && ops_e == OPW'(2);
  assign fits     = in_br || is_one || (is_crk && cnt <= 3'd2) || (cnt == 3'd0);
  assign in_ready = !closed && !mc_on && !flush && fits;
  assign take     = in_valid && in_ready;

  assign grp_valid    = closed && !flush && (outst < CW'(NGRP));
  assign fire         = grp_valid && be_ready;
  assign grp_slot_vld = sv;
  assign grp_tag      = tag;

  for (genvar i = 0; i < NSL; i++) begin : g_out
    assign grp_slots[i*SW +: SW] = sv[i] ? sd[i] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      closed  <= 1'b0;
      cnt     <= '0;
      sv      <= '0;
      mc_on   <= 1'b0;
      mc_left <= '0;
      mc_idx  <= '0;
      mc_id   <= '0;
      tag     <= '0;
      outst   <= '0;
      for (int i = 0; i < NSL; i++) sd[i] <= '0;
    end else begin
      outst <= outst + CW'(fire) - CW'(cmp_valid);
      if (fire) tag <= (tag == TW'(NGRP - 1)) ? '0 : tag + TW'(1);

      if (flush) begin
        closed <= 1'b0;
        cnt    <= '0;
        sv     <= '0;
        mc_on  <= 1'b0;
      end else if (fire) begin
        closed <= 1'b0;
        cnt    <= '0;
        sv     <= '0;
      end else if (!closed) begin
        if (mc_on) begin
          sd[cnt]  <= {mc_id, mc_idx};
          sv[cnt]  <= 1'b1;
          cnt      <= cnt + 3'd1;
          mc_idx   <= mc_idx + OPW'(1);
          mc_left  <= mc_left - OPW'(1);
          if (mc_left == OPW'(1)) mc_on <= 1'b0;
          if (mc_left == OPW'(1) || cnt == 3'd3) closed <= 1'b1;
        end else if (take) begin
          if (in_br) begin
            sd[4]  <= {in_id, OPW'(0)};
            sv[4]  <= 1'b1;
            closed <= 1'b1;
          end else if (is_one) begin
            sd[cnt] <= {in_id, OPW'(0)};
            sv[cnt] <= 1'b1;
            cnt     <= cnt + 3'd1;
            if (cnt == 3'd3) closed <= 1'b1;
          end else if (is_crk) begin
            sd[cnt]        <= {in_id, OPW'(0)};
            sd[cnt + 3'd1] <= {in_id, OPW'(1)};
            sv[cnt]        <= 1'b1;
            sv[cnt + 3'd1] <= 1'b1;
            cnt            <= cnt + 3'd2;
            if (cnt == 3'd2) closed <= 1'b1;
          end else begin
            sd[0]   <= {in_id, OPW'(0)};
            sv[0]   <= 1'b1;
            cnt     <= 3'd1;
            mc_on   <= 1'b1;
            mc_id   <= in_id;
            mc_idx  <= OPW'(1);
            mc_left <= ops_e - OPW'(1);
          end
        end else if (in_valid) begin
          closed <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/group_former_chk.sv
module group_former_chk #(
  parameter int NGRP = 20,
  parameter int TW   = 5,
  parameter int SW   = 12,
  localparam int CW  = $clog2(NGRP + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic            in_ready,
  input logic            be_ready,
  input logic            cmp_valid,
  input logic            grp_valid,
  input logic [4:0]      grp_slot_vld,
  input logic [5*SW-1:0] grp_slots,
  input logic [TW-1:0]   grp_tag
);

  logic [CW-1:0] cnt_out;
  logic [TW-1:0] nxt_tag;
  logic          fired;

  assign fired = grp_valid && be_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_out <= '0;
      nxt_tag <= '0;
    end else begin
      cnt_out <= cnt_out + CW'(fired) - CW'(cmp_valid);
      if (fired) nxt_tag <= (grp_tag == TW'(NGRP - 1)) ? '0 : grp_tag + TW'(1);
    end
  end

  a_r1_slot_shape: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |-> (grp_slot_vld != 5'd0) &&
                  ((grp_slot_vld[3:0] & (grp_slot_vld[3:0] + 4'd1)) == 4'd0));

  a_r6_no_intake_while_offered: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |-> !in_ready);

  a_r7_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && !be_ready) |=> flush ||
      (grp_valid && $stable(grp_slots) && $stable(grp_slot_vld) && $stable(grp_tag)));

  a_r8_tag_order: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |-> grp_tag == nxt_tag);

  a_r9_cap: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |-> cnt_out < CW'(NGRP));

  a_r9_completion_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> cnt_out != '0);

  a_r10_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !grp_valid && !in_ready);

endmodule

bind group_former group_former_chk #(.NGRP(NGRP), .TW(TW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_ready(in_ready),
  .be_ready(be_ready), .cmp_valid(cmp_valid), .grp_valid(grp_valid),
  .grp_slot_vld(grp_slot_vld), .grp_slots(grp_slots), .grp_tag(grp_tag)
);

// File: tb/sim_group_former.sv
module sim_group_former;
  localparam int CLK_NS = 10;
  localparam int NGRP = 20;
  localparam int IDW = 8;
  localparam int OPW = 4;
  localparam int SW = IDW + OPW;
  localparam int TW = $clog2(NGRP);

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, in_valid = 1'b0, in_br = 1'b0;
  logic be_ready = 1'b0, cmp_valid = 1'b0;
  logic [IDW-1:0] in_id = '0;
  logic [OPW-1:0] in_ops = '0;
  logic in_ready, grp_valid;
  logic [4:0] grp_slot_vld;
  logic [5*SW-1:0] grp_slots;
  logic [TW-1:0] grp_tag;

  group_former #(.NGRP(NGRP), .IDW(IDW), .OPW(OPW)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .in_id(in_id), .in_ops(in_ops), .in_br(in_br), .be_ready(be_ready),
    .cmp_valid(cmp_valid), .grp_valid(grp_valid), .grp_slot_vld(grp_slot_vld),
    .grp_slots(grp_slots), .grp_tag(grp_tag));

  always #(CLK_NS / 2) clk = ~clk;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  bit m_closed;
  int m_cnt, m_tag, m_out;
  bit m_sv[5];
  int m_sd[5];
  int mcq[$];
  int next_id = 1;

  task automatic m_reset();
    m_closed = 0; m_cnt = 0; m_tag = 0; m_out = 0;
    for (int i = 0; i < 5; i++) begin m_sv[i] = 0; m_sd[i] = 0; end
    mcq.delete();
  endtask

  task automatic m_clear();
    m_closed = 0; m_cnt = 0;
    for (int i = 0; i < 5; i++) m_sv[i] = 0;
  endtask

  task automatic chk(string req, string fld, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, fld, act, exp, $time);
    end
  endtask

  task automatic cyc(bit v, bit br, int ops, bit ber, bit cmp, bit fl, string req);
    int opse;
    bit fits, e_rdy, e_gv, fire, took;
    logic [4:0] e_vld;
    logic [5*SW-1:0] e_dat;
    in_valid = v; in_br = br; in_ops = OPW'(ops); in_id = IDW'(next_id);
    be_ready = ber; flush = fl;
    cmp_valid = cmp && rst_n && (m_out > 0);
    #1;
    opse = (ops == 0) ? 1 : ops;
    fits = br || opse == 1 || (opse == 2 && m_cnt <= 2) || m_cnt == 0;
    e_rdy = !m_closed && mcq.size() == 0 && !fl && fits;
    e_gv = m_closed && !fl && m_out < NGRP;
    e_vld = '0; e_dat = '0;
    for (int i = 0; i < 5; i++) if (m_sv[i]) begin
      e_vld[i] = 1'b1;
      e_dat[i*SW +: SW] = SW'(m_sd[i]);
    end
    chk(req, "in_ready(R6)", 64'(in_ready), 64'(e_rdy));
    chk(req, "grp_valid(R7)", 64'(grp_valid), 64'(e_gv));
    if (e_gv) begin
      chk(req, "slot_vld(R1)", 64'(grp_slot_vld), 64'(e_vld));
      chk(req, "slots(R2)", 64'(grp_slots), 64'(e_dat));
      chk(req, "tag(R8)", 64'(grp_tag), 64'(m_tag));
    end
    took = 0;
    if (!rst_n) m_reset();
    else begin
      fire = e_gv && ber;
      if (fire) begin m_tag = (m_tag + 1) % NGRP; m_out++; end
      if (cmp_valid) m_out--;
      if (fl) begin m_clear(); mcq.delete(); end
      else if (fire) m_clear();
      else if (!m_closed) begin
        if (mcq.size() > 0) begin
          m_sd[m_cnt] = mcq.pop_front(); m_sv[m_cnt] = 1; m_cnt++;
          if (mcq.size() == 0 || m_cnt == 4) m_closed = 1;
        end else if (v && e_rdy) begin
          took = 1;
          if (br) begin m_sd[4] = next_id << OPW; m_sv[4] = 1; m_closed = 1; end
          else if (opse == 1) begin
            m_sd[m_cnt] = next_id << OPW; m_sv[m_cnt] = 1; m_cnt++;
            if (m_cnt == 4) m_closed = 1;
          end else if (opse == 2) begin
            m_sd[m_cnt] = next_id << OPW; m_sv[m_cnt] = 1;
            m_sd[m_cnt+1] = (next_id << OPW) | 1; m_sv[m_cnt+1] = 1; m_cnt += 2;
            if (m_cnt == 4) m_closed = 1;
          end else begin
            m_sd[0] = next_id << OPW; m_sv[0] = 1; m_cnt = 1;
            for (int k = 1; k < opse; k++) mcq.push_back((next_id << OPW) | k);
          end
        end else if (v) m_closed = 1;
      end
    end
    @(posedge clk);
    if (took) next_id = (next_id + 1) % (1 << IDW);
    @(negedge clk);
  endtask

  task automatic issue(bit br, int ops, string req);
    int start = next_id;
    for (int n = 0; n < 60 && next_id == start; n++) cyc(1, br, ops, 1, 0, 0, req);
  endtask

  task automatic idle(int n, bit ber, bit cmp, string req);
    for (int i = 0; i < n; i++) cyc(0, 0, 1, ber, cmp, 0, req);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    m_reset();
    @(negedge clk);
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, 1, 0, 0, "R11");
    rst_n = 1'b1;
    cyc(0, 0, 1, 0, 0, 0, "R11");

    for (int i = 0; i < 4; i++) issue(0, 1, "R3");
    issue(0, 0, "R3");
    idle(3, 1, 0, "R3");

    for (int i = 0; i < 3; i++) issue(0, 1, "R4");
    issue(0, 2, "R4");
    issue(0, 2, "R4");
    issue(0, 2, "R4");
    idle(3, 1, 1, "R4");

    issue(0, 1, "R1");
    issue(1, 5, "R1");
    idle(3, 1, 1, "R1");

    issue(0, 1, "R5");
    issue(0, 7, "R5");
    for (int i = 0; i < 10; i++) cyc(1, 0, 1, 1, 0, 0, "R5");
    idle(3, 1, 1, "R5");

    for (int i = 0; i < 3; i++) issue(0, 1, "R7");
    issue(1, 1, "R7");
    idle(6, 0, 0, "R7");
    idle(2, 1, 1, "R7");

    for (int i = 0; i < 26; i++) issue(1, 1, "R9");
    idle(5, 1, 0, "R9");
    for (int i = 0; i < NGRP + 4; i++) cyc(0, 0, 1, 1, 1, 0, "R8");

    issue(0, 1, "R10");
    issue(0, 1, "R10");
    cyc(0, 0, 1, 1, 0, 1, "R10");
    issue(0, 9, "R10");
    cyc(1, 0, 1, 1, 0, 0, "R10");
    cyc(1, 0, 1, 1, 0, 1, "R10");
    issue(0, 2, "R10");
    idle(3, 1, 1, "R10");

    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      int ops;
      bit br = (r < 15);
      if (r < 65) ops = 1;
      else if (r < 70) ops = 0;
      else if (r < 85) ops = 2;
      else ops = $urandom_range(3, 12);
      cyc($urandom_range(0, 99) < 80, br, ops, $urandom_range(0, 99) < 75,
          $urandom_range(0, 99) < 40, $urandom_range(0, 99) < 2, "R2");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule